// File: doc/BRIEF.md
# Sequential Byte Multiply/Divide Engine

This unit performs an unsigned 8-bit by 8-bit multiplication or an unsigned 8-bit by 8-bit division on a pair of byte operands called A and B. A request is raised with a one-cycle start strobe that carries the operation select and both operands. The unit then iterates one bit per clock: a shift-and-add multiplier or a restoring divider. It reports its results on a one-cycle done pulse.

When the unit finishes a multiply, the 16-bit product is split across the two result bytes. When it finishes a divide, the quotient and the remainder go to the two result bytes. Carry and overflow flags are reported with the result. A zero divisor is recognised when the request is accepted and takes an early exit: no iterations run. The result bytes and flags hold their values until the next operation completes. The surrounding core chooses the operands and writes the results back, so the unit has no register file and no instruction decode.

Top module: `muldiv_unit`

## Requirements
- R1: For a multiply (op_i = 0), result byte A is the low 8 bits of A×B and result byte B is the high 8 bits.
- R2: After a multiply, the carry flag is 0 and the overflow flag is 1 exactly when the product is 256 or more.
- R3: For a divide (op_i = 1) with a nonzero divisor, result byte A is floor(A/B) and result byte B is A mod B.
- R4: A divide with a nonzero divisor ends with both carry and overflow cleared.
- R5: A divide with B = 0 ends with overflow set and carry cleared. The result bytes equal the A and B operands unchanged. done_o rises in the cycle right after the start edge, and busy_o never rises.
- R6: A request accepted at a clock edge keeps busy_o high for exactly 8 cycles. done_o is high in the cycle that follows those 8 cycles, and busy_o is low in that cycle.
- R7: A start strobe that arrives while busy_o is high is ignored: the running operation completes with its own operands, operation and timing.
- R8: After a synchronous reset, busy_o, done_o, the result bytes and both flags are 0.
- R9: done_o lasts a single cycle unless a new request is accepted in that cycle, and it is never high together with busy_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted while busy_o is low |
| op_i | input | 1 | Operation select: 0 multiply, 1 divide |
| a_i | input | 8 | Operand A (multiplicand / dividend) |
| b_i | input | 8 | Operand B (multiplier / divisor) |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | 8 | Result byte A: product low byte or quotient |
| b_o | output | 8 | Result byte B: product high byte or remainder |
| cy_o | output | 1 | Carry flag of the last operation |
| ov_o | output | 1 | Overflow flag of the last operation |

## Verification
Two functions can fall in the same cycle. The first is the completion of a running operation. The second is the handling of a new start strobe, either one that arrives during the final iteration cycle or one that arrives in the done cycle itself. The bench raises start with different operands in the last busy cycle and expects that strobe to be dropped, leaving the original result intact. The bench also issues back-to-back requests, where the next request is raised in the done cycle. These include a zero-divisor request, which must produce a second done pulse on the very next cycle with the flags of the new request.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int unsigned MD_W = 8;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } md_state_e;

    typedef struct packed {
        logic [MD_W-1:0] lo;
        logic [MD_W-1:0] hi;
        logic            cy;
        logic            ov;
    } md_result_t;

    function automatic md_result_t pack_result(input logic [MD_W-1:0] lo,
                                               input logic [MD_W-1:0] hi,
                                               input logic cy,
                                               input logic ov);
        md_result_t r;
        r.lo = lo;
        r.hi = hi;
        r.cy = cy;
        r.ov = ov;
        return r;
    endfunction

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
    parameter int unsigned ITER = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic div_zero_i,
    output logic accept_o,
    output logic load_o,
    output logic zero_exit_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    import muldiv_pkg::*;

    localparam int unsigned CW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(ITER - 1);

    md_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    assign busy_o      = (state_q == ST_RUN);
    assign done_o      = (state_q == ST_DONE);
    assign accept_o    = start_i && !busy_o;
    assign zero_exit_o = accept_o && div_zero_i;
    assign load_o      = accept_o && !div_zero_i;
    assign step_o      = busy_o;
    assign last_o      = busy_o && (cnt_q == LAST_CNT);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (last_o) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                if (zero_exit_o) begin
                    state_d = ST_DONE;
                end else if (load_o) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R9: completion and iteration are exclusive
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R9: done is a single pulse without a new accepted request
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> !done_o);

    // R7: a running operation stays busy until its final iteration
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o && !last_o |=> busy_o);

    // R6: the final iteration is followed by the done cycle
    p_last_done_r6: assert property (@(posedge clk) disable iff (rst)
        last_o |=> done_o && !busy_o);

    // R5: a zero divisor goes straight to completion
    p_zero_exit_r5: assert property (@(posedge clk) disable iff (rst)
        zero_exit_o |=> done_o && !busy_o);

endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic [W-1:0] nxt_hi_o,
    output logic [W-1:0] nxt_lo_o
);
    logic [W-1:0] hi_q, lo_q, mcand_q;
    logic [W:0]   sum;

    // add the multiplicand when the current multiplier bit is set
    assign sum      = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    assign nxt_hi_o = sum[W:1];
    assign nxt_lo_o = {sum[0], lo_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            lo_q    <= '0;
            mcand_q <= '0;
        end else if (load_i) begin
            hi_q    <= '0;
            lo_q    <= mplier_i;
            mcand_q <= mcand_i;
        end else if (step_i) begin
            hi_q    <= nxt_hi_o;
            lo_q    <= nxt_lo_o;
        end
    end

    // R1: the partial-product high half never exceeds the multiplicand
    p_partial_bound_r1: assert property (@(posedge clk) disable iff (rst)
        hi_q <= mcand_q);

endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] nxt_quo_o,
    output logic [W-1:0] nxt_rem_o
);
    logic [W-1:0] rem_q, quo_q, dvs_q;
    logic         loaded_q;
    logic [W:0]   trial;
    logic [W-1:0] sub_lo;
    logic         fits;

    // shift the next dividend bit into the partial remainder, then trial subtract
    assign trial     = {rem_q, quo_q[W-1]};
    assign fits      = (trial >= {1'b0, dvs_q});
    assign sub_lo    = trial[W-1:0] - dvs_q;
    assign nxt_rem_o = fits ? sub_lo : trial[W-1:0];
    assign nxt_quo_o = {quo_q[W-2:0], fits};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            quo_q    <= '0;
            dvs_q    <= '0;
            loaded_q <= 1'b0;
        end else if (load_i) begin
            rem_q    <= '0;
            quo_q    <= dvd_i;
            dvs_q    <= dvs_i;
            loaded_q <= 1'b1;
        end else if (step_i) begin
            rem_q    <= nxt_rem_o;
            quo_q    <= nxt_quo_o;
        end
    end

    // R3: the partial remainder always stays below the divisor
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> rem_q < dvs_q);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int unsigned W = muldiv_pkg::MD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic         cy_o,
    output logic         ov_o
);
    import muldiv_pkg::*;

    localparam int unsigned ITER = W;

    md_op_e       op_q;
    logic         div_zero, accept, load, zero_exit, step, last;
    logic [W-1:0] mul_hi, mul_lo, div_quo, div_rem;
    logic [W-1:0] res_lo_q, res_hi_q;
    logic         res_cy_q, res_ov_q;

    assign div_zero = (md_op_e'(op_i) == OP_DIV) && (b_i == '0);

    muldiv_ctrl #(.ITER(ITER)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .div_zero_i (div_zero),
        .accept_o   (accept),
        .load_o     (load),
        .zero_exit_o(zero_exit),
        .step_o     (step),
        .last_o     (last),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    muldiv_mul_core #(.W(W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load && (md_op_e'(op_i) == OP_MUL)),
        .step_i   (step && (op_q == OP_MUL)),
        .mcand_i  (a_i),
        .mplier_i (b_i),
        .nxt_hi_o (mul_hi),
        .nxt_lo_o (mul_lo)
    );

    muldiv_div_core #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load && (md_op_e'(op_i) == OP_DIV)),
        .step_i   (step && (op_q == OP_DIV)),
        .dvd_i    (a_i),
        .dvs_i    (b_i),
        .nxt_quo_o(div_quo),
        .nxt_rem_o(div_rem)
    );

    md_result_t res_d;

    always_comb begin
        res_d = pack_result(res_lo_q, res_hi_q, res_cy_q, res_ov_q);
        if (zero_exit) begin
            res_d = pack_result(a_i, b_i, 1'b0, 1'b1);
        end else if (last) begin
            if (op_q == OP_MUL) begin
                res_d = pack_result(mul_lo, mul_hi, 1'b0, (mul_hi != '0));
            end else begin
                res_d = pack_result(div_quo, div_rem, 1'b0, 1'b0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= OP_MUL;
            res_lo_q <= '0;
            res_hi_q <= '0;
            res_cy_q <= 1'b0;
            res_ov_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q <= md_op_e'(op_i);
            end
            res_lo_q <= res_d.lo;
            res_hi_q <= res_d.hi;
            res_cy_q <= res_d.cy;
            res_ov_q <= res_d.ov;
        end
    end

    assign a_o  = res_lo_q;
    assign b_o  = res_hi_q;
    assign cy_o = res_cy_q;
    assign ov_o = res_ov_q;

    // R2 / R4: carry is clear whenever a result is presented
    p_carry_clear_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !cy_o);

    // R7: results do not move while iterating
    p_result_stable_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o && !last |=> $stable(a_o) && $stable(b_o));

    // R5: a zero-divisor exit passes both operands through untouched
    p_zero_passthru_r5: assert property (@(posedge clk) disable iff (rst)
        zero_exit |=> ov_o && a_o == $past(a_i) && b_o == $past(b_i));

endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic       op_i;
    logic [7:0] a_i, b_i;
    logic       busy_o, done_o, cy_o, ov_o;
    logic [7:0] a_o, b_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    muldiv_unit uut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
        .a_o(a_o), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o)
    );

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic       cy;
        logic       ov;
    } exp_t;

    function automatic exp_t model(input logic op, input logic [7:0] a, input logic [7:0] b);
        exp_t e;
        int unsigned p;
        if (!op) begin
            p    = a * b;
            e.a  = p[7:0];
            e.b  = p[15:8];
            e.cy = 1'b0;
            e.ov = (p >= 256);
        end else if (b == 0) begin
            e.a = a; e.b = b; e.cy = 1'b0; e.ov = 1'b1;
        end else begin
            e.a = a / b; e.b = a % b; e.cy = 1'b0; e.ov = 1'b0;
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // issue a request at the next edge; optionally strobe a foreign request mid-run
    task automatic run_op(input logic op, input logic [7:0] a, input logic [7:0] b,
                          input bit intrude, input bit chain_zero);
        exp_t e;
        int   n;
        int   want;
        e = model(op, a, b);
        want = (op && b == 0) ? 1 : 9;
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0; a_i = ~a; b_i = ~b; op_i = ~op;
        n = 1;
        while (!done_o && n < 40) begin
            if (intrude && n == 8) start_i = 1'b1;   // R7: final busy cycle
            if (intrude && n == 4) begin start_i = 1'b1; op_i = ~op; end
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        if (op && b == 0) check(n == want, "R5 latency", n, want);
        else              check(n == want, "R6 latency", n, want);
        check(!busy_o, "R9 busy low at done", busy_o, 0);
        if (!op) begin
            check(a_o == e.a, "R1 low byte", a_o, e.a);
            check(b_o == e.b, "R1 high byte", b_o, e.b);
            check(ov_o == e.ov && cy_o == e.cy, "R2 flags", {cy_o, ov_o}, {e.cy, e.ov});
        end else if (b != 0) begin
            check(a_o == e.a, "R3 quotient", a_o, e.a);
            check(b_o == e.b, "R3 remainder", b_o, e.b);
            check(ov_o == 0 && cy_o == 0, "R4 flags", {cy_o, ov_o}, 0);
        end else begin
            check(a_o == a && b_o == b, "R5 operands kept", {a_o, b_o}, {a, b});
            check(ov_o == 1 && cy_o == 0, "R5 flags", {cy_o, ov_o}, 1);
        end
        if (intrude) check(a_o == e.a && b_o == e.b, "R7 intruding start ignored", {a_o, b_o}, {e.a, e.b});
        if (chain_zero) begin
            // R9: new zero-divisor request in the done cycle yields a second pulse
            start_i = 1'b1; op_i = 1'b1; a_i = 8'h5A; b_i = 8'h00;
            @(negedge clk);
            start_i = 1'b0;
            check(done_o == 1, "R9 chained done", done_o, 1);
            check(a_o == 8'h5A && ov_o == 1, "R5 chained zero divide", {a_o, 7'b0, ov_o}, {8'h5A, 8'h01});
            @(negedge clk);
        end else begin
            @(negedge clk);
        end
        check(!done_o, "R9 single pulse", done_o, 0);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        summary();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        rst = 1'b1; start_i = 1'b0; op_i = 1'b0; a_i = '0; b_i = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!busy_o && !done_o, "R8 control idle", {busy_o, done_o}, 0);
        check(a_o == 0 && b_o == 0 && !cy_o && !ov_o, "R8 results cleared",
              {a_o, b_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o, "R8 idle after release", {busy_o, done_o}, 0);

        // directed corners
        run_op(1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0);
        run_op(1'b0, 8'd16, 8'd16, 1'b0, 1'b0);
        run_op(1'b0, 8'd15, 8'd17, 1'b0, 1'b0);
        run_op(1'b0, 8'd0,  8'd200, 1'b0, 1'b0);
        run_op(1'b0, 8'd1,  8'd255, 1'b0, 1'b0);
        run_op(1'b1, 8'd255, 8'd1, 1'b0, 1'b0);
        run_op(1'b1, 8'd7,  8'd9,  1'b0, 1'b0);
        run_op(1'b1, 8'd0,  8'd5,  1'b0, 1'b0);
        run_op(1'b1, 8'd200, 8'd0, 1'b0, 1'b0);
        run_op(1'b1, 8'd255, 8'd255, 1'b0, 1'b0);
        run_op(1'b0, 8'd77, 8'd3, 1'b1, 1'b0);
        run_op(1'b1, 8'd250, 8'd7, 1'b1, 1'b1);
        run_op(1'b0, 8'd33, 8'd99, 1'b0, 1'b1);

        // constrained random
        for (int i = 0; i < 300; i++) begin
            logic       op;
            logic [7:0] a, b;
            op = 1'($urandom);
            a  = 8'($urandom);
            b  = ($urandom % 8 == 0) ? 8'd0 : 8'($urandom);
            run_op(op, a, b, ($urandom % 5) == 0, ($urandom % 7) == 0);
        end
        summary();
    end

endmodule